// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block is the acknowledge and end-of-interrupt logic of one processor's interface to an interrupt controller. An acknowledge request takes the highest-pending interrupt offered by the arbiter. It is taken only if that interrupt's priority beats the priority of the interrupt now running. When it is taken, the interrupt becomes the new running interrupt and the arbiter is told to drop its pending state.

Every interrupt ID keeps one link that records which interrupt it preempted. Together these links form a chain that runs from the running interrupt back to idle. Completing the running interrupt pops one level: the running ID and running priority return to the preempted one. Completing an interrupt deeper in the chain starts a walk that visits one link per clock and splices that interrupt out. During the walk, `busy` is high and new requests are dropped.

Completion of a level-triggered interrupt whose line is still asserted issues a pending-set command back to the arbiter. ID 1023 means "no interrupt" everywhere. The running priority is one bit wider than a table priority so that it can hold the idle value.

Top module: `irq_ack_tracker`

## Requirements
- R1: An accepted acknowledge produces a one-cycle `ack_valid` pulse with `ack_id`, registered one clock after the request. `ack_id` is 1023 when `hp_id` is not below NUM_IRQ (this includes 1023), or when the table priority of `hp_id` is not strictly lower than `run_prio`. Otherwise `ack_id` equals `hp_id`.
- R2: A successful acknowledge makes `hp_id` the running ID and loads its table priority, zero-extended, into `run_prio`. The previous running ID is kept as the new interrupt's link.
- R3: A successful acknowledge issues a one-cycle `clr_valid` with `clr_id` equal to the taken ID. `clr_all` is 1 when that ID's `model_1n` bit is 1, meaning clear for every processor, and 0 otherwise, meaning clear for this processor only. A refused acknowledge issues no clear.
- R4: An end-of-interrupt request is ignored, with no state change and no command, when `eoi_id` is at or above NUM_IRQ, or when the running ID is 1023.
- R5: For an end-of-interrupt request that is not ignored, a one-cycle `set_valid` with `set_id` = `eoi_id` is issued when all four of these hold for that ID: `trig_edge` is 0 (level), `level_in` is 1, `enabled` is 1 and `targets_me` is 1.
- R6: Completing the running ID makes its link the running ID. `run_prio` becomes that ID's table priority, or 0x100 (with the default 8-bit priorities) when the link is 1023.
- R7: Completing a non-running ID raises `busy` for one cycle per link visited. The walk starts at the running ID and stops at a node whose link is 1023 or at a node whose link is the completed ID. In the second case, that node's link is replaced by the completed ID's link. The running ID and running priority do not change during the walk.
- R8: Acknowledge and end-of-interrupt requests arriving while `busy` is high are ignored. When both requests arrive in the same idle cycle, only the acknowledge is served.
- R9: After reset the running ID is 1023, `run_prio` is 0x100, `busy` is 0, and no command or acknowledge pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request strobe |
| hp_id | input | 10 | Highest-pending ID from the arbiter (1023 = none) |
| prio_flat | input | NUM_IRQ*PRIO_W | Priority table, entry i at bits [i*PRIO_W +: PRIO_W] |
| eoi_req | input | 1 | End-of-interrupt request strobe |
| eoi_id | input | 10 | ID being completed |
| trig_edge | input | NUM_IRQ | Per ID: 1 = edge triggered, 0 = level |
| model_1n | input | NUM_IRQ | Per ID: 1 = clear pending for all processors on acknowledge |
| level_in | input | NUM_IRQ | Per ID input line level for this processor |
| enabled | input | NUM_IRQ | Per ID enable for this processor |
| targets_me | input | NUM_IRQ | Per ID: this processor is a target |
| busy | output | 1 | Chain walk in progress; requests ignored |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| run_id | output | 10 | Running ID (1023 = idle) |
| run_prio | output | PRIO_W+1 | Running priority (idle = 1 << PRIO_W) |
| clr_valid | output | 1 | Pending-clear command |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all processors |
| set_valid | output | 1 | Pending-set command |
| set_id | output | 10 | ID to mark pending |

## Verification
The bench goes after three kinds of corner case.

The first is priority ties. If a tie were wrongly accepted, an equal-priority interrupt would nest on top of itself.

The second is out-of-order completion at the middle and at the tail of a chain, and of an ID that is not in the chain at all. A design that popped a stack here would restore the wrong running ID. A design that walked for the wrong length would hold `busy` for a different number of cycles. A design that spliced wrongly would skip an interrupt when a later completion pops the chain.

The third covers ignored requests: completions with out-of-range IDs, completions while idle, and any request while busy. If any of these leaked, the running ID would move or a stray set command would appear. The re-pend condition is varied term by term; a design missing one term would issue a set command for an edge-triggered, low, disabled or untargeted line.

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_req,
  input  logic [9:0]                hp_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  input  logic                      eoi_req,
  input  logic [9:0]                eoi_id,
  input  logic [NUM_IRQ-1:0]        trig_edge,
  input  logic [NUM_IRQ-1:0]        model_1n,
  input  logic [NUM_IRQ-1:0]        level_in,
  input  logic [NUM_IRQ-1:0]        enabled,
  input  logic [NUM_IRQ-1:0]        targets_me,
  output logic                      busy,
  output logic                      ack_valid,
  output logic [9:0]                ack_id,
  output logic [9:0]                run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      clr_valid,
  output logic [9:0]                clr_id,
  output logic                      clr_all,
  output logic                      set_valid,
  output logic [9:0]                set_id
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [9:0] IDLE_ID = 10'd1023;
  localparam logic [9:0] LIMIT = 10'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W-1:0] prio_of [NUM_IRQ];
  logic [9:0]        link_q  [NUM_IRQ];
  logic [9:0]        run_id_q;
  logic [PRIO_W:0]   run_prio_q;
  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [9:0]        tgt_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    assign prio_of[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  wire [IDX_W-1:0] hp_idx   = hp_id[IDX_W-1:0];
  wire [IDX_W-1:0] eoi_idx  = eoi_id[IDX_W-1:0];
  wire [IDX_W-1:0] run_idx  = run_id_q[IDX_W-1:0];
  wire [IDX_W-1:0] tgt_idx  = tgt_q[IDX_W-1:0];
  wire [9:0]       run_link = link_q[run_idx];
  wire [9:0]       walk_nxt = link_q[cur_q];

  wire ack_take = (hp_id < LIMIT) && ({1'b0, prio_of[hp_idx]} < run_prio_q);
  wire eoi_ok   = (eoi_id < LIMIT) && (run_id_q != IDLE_ID);
  wire repend   = !trig_edge[eoi_idx] && level_in[eoi_idx] &&
                  enabled[eoi_idx] && targets_me[eoi_idx];
  wire [PRIO_W:0] link_prio = (run_link == IDLE_ID) ? IDLE_PRIO
                            : {1'b0, prio_of[run_link[IDX_W-1:0]]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q   <= IDLE_ID;
      run_prio_q <= IDLE_PRIO;
      busy_q     <= 1'b0;
      cur_q      <= '0;
      tgt_q      <= IDLE_ID;
      ack_valid  <= 1'b0;
      ack_id     <= IDLE_ID;
      clr_valid  <= 1'b0;
      clr_id     <= '0;
      clr_all    <= 1'b0;
      set_valid  <= 1'b0;
      set_id     <= '0;
      for (int i = 0; i < NUM_IRQ; i++) link_q[i] <= IDLE_ID;
    end else begin
      ack_valid <= 1'b0;
      clr_valid <= 1'b0;
      set_valid <= 1'b0;
      if (busy_q) begin
        if (walk_nxt == IDLE_ID) begin
          busy_q <= 1'b0;
        end else if (walk_nxt == tgt_q) begin
          link_q[cur_q] <= link_q[tgt_idx];
          busy_q        <= 1'b0;
        end else begin
          cur_q <= walk_nxt[IDX_W-1:0];
        end
      end else if (ack_req) begin
        ack_valid <= 1'b1;
        if (ack_take) begin
          ack_id         <= hp_id;
          link_q[hp_idx] <= run_id_q;
          run_id_q       <= hp_id;
          run_prio_q     <= {1'b0, prio_of[hp_idx]};
          clr_valid      <= 1'b1;
          clr_id         <= hp_id;
          clr_all        <= model_1n[hp_idx];
        end else begin
          ack_id <= IDLE_ID;
        end
      end else if (eoi_req && eoi_ok) begin
        if (repend) begin
          set_valid <= 1'b1;
          set_id    <= eoi_id;
        end
        if (eoi_id == run_id_q) begin
          run_id_q   <= run_link;
          run_prio_q <= link_prio;
        end else begin
          busy_q <= 1'b1;
          cur_q  <= run_idx;
          tgt_q  <= eoi_id;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
endmodule

// File: rtl/irq_ack_tracker_chk.sv
module irq_ack_tracker_chk #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_req,
  input logic            eoi_req,
  input logic [9:0]      eoi_id,
  input logic            busy,
  input logic            ack_valid,
  input logic [9:0]      ack_id,
  input logic [9:0]      run_id,
  input logic [PRIO_W:0] run_prio,
  input logic            clr_valid,
  input logic [9:0]      clr_id,
  input logic            set_valid
);
  localparam logic [9:0] LIMIT = 10'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  p_idle_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == 10'd1023) |-> (run_prio == IDLE_PRIO));

  p_ack_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id != 10'd1023) |-> (run_id == ack_id));

  p_clr_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (ack_valid && ack_id == clr_id));

  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack_valid);

  p_walk_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(run_id) && $stable(run_prio)));

  p_bad_eoi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !busy && !ack_req && eoi_id >= LIMIT)
      |=> (!set_valid && !busy && $stable(run_id)));
endmodule

bind irq_ack_tracker irq_ack_tracker_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .eoi_req(eoi_req),
  .eoi_id(eoi_id), .busy(busy), .ack_valid(ack_valid), .ack_id(ack_id),
  .run_id(run_id), .run_prio(run_prio), .clr_valid(clr_valid),
  .clr_id(clr_id), .set_valid(set_valid)
);

// File: tb/irq_ack_tracker_bench.sv
`timescale 1ns/1ps
module irq_ack_tracker_bench;
  localparam int N = 64;
  localparam int PW = 8;

  logic clk = 0, rst_n = 0;
  logic ack_req = 0, eoi_req = 0;
  logic [9:0] hp_id = 10'd1023, eoi_id = 10'd1023;
  logic [N*PW-1:0] prio_flat = '0;
  logic [N-1:0] trig_edge = '0, model_1n = '0, level_in = '0, enabled = '0, targets_me = '0;
  logic busy, ack_valid, clr_valid, clr_all, set_valid;
  logic [9:0] ack_id, run_id, clr_id, set_id;
  logic [PW:0] run_prio;

  always #4 clk = ~clk;

  irq_ack_tracker #(.NUM_IRQ(N), .PRIO_W(PW)) u_irq_ack_tracker (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id), .prio_flat(prio_flat),
    .eoi_req(eoi_req), .eoi_id(eoi_id), .trig_edge(trig_edge), .model_1n(model_1n),
    .level_in(level_in), .enabled(enabled), .targets_me(targets_me), .busy(busy),
    .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
    .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all),
    .set_valid(set_valid), .set_id(set_id));

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference
  int m_run, m_rprio, m_link[N], m_busy, m_unlink, m_tgt;
  int e_ack_v, e_ack_id, e_clr_v, e_clr_id, e_clr_all, e_set_v, e_set_id;

  function automatic int prio(int id);
    return int'(prio_flat[id*PW +: PW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1023; m_rprio = 256; m_busy = 0; m_unlink = -1; m_tgt = 1023;
      for (int i = 0; i < N; i++) m_link[i] = 1023;
      e_ack_v = 0; e_ack_id = 1023; e_clr_v = 0; e_clr_id = 0; e_clr_all = 0;
      e_set_v = 0; e_set_id = 0;
    end else begin
      e_ack_v = 0; e_clr_v = 0; e_set_v = 0;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0 && m_unlink >= 0) m_link[m_unlink] = m_link[m_tgt];
      end else if (ack_req) begin
        e_ack_v = 1;
        if (int'(hp_id) < N && prio(int'(hp_id)) < m_rprio) begin
          e_ack_id = int'(hp_id);
          m_link[hp_id] = m_run;
          m_run = int'(hp_id); m_rprio = prio(m_run);
          e_clr_v = 1; e_clr_id = int'(hp_id); e_clr_all = int'(model_1n[hp_id]);
        end else e_ack_id = 1023;
      end else if (eoi_req && int'(eoi_id) < N && m_run != 1023) begin
        int t;
        t = int'(eoi_id);
        if (!trig_edge[t] && level_in[t] && enabled[t] && targets_me[t]) begin
          e_set_v = 1; e_set_id = t;
        end
        if (t == m_run) begin
          m_run = m_link[t];
          m_rprio = (m_run == 1023) ? 256 : prio(m_run);
        end else begin
          int node, visits;
          node = m_run; visits = 0; m_unlink = -1; m_tgt = t;
          forever begin
            visits++;
            if (m_link[node] == 1023) break;
            if (m_link[node] == t) begin m_unlink = node; break; end
            node = m_link[node];
          end
          m_busy = visits;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R7", "busy", int'(busy), int'(m_busy > 0));
    chk("R2", "run_id", int'(run_id), m_run);
    chk("R6", "run_prio", int'(run_prio), m_rprio);
    chk("R1", "ack_valid", int'(ack_valid), e_ack_v);
    if (e_ack_v != 0) chk("R1", "ack_id", int'(ack_id), e_ack_id);
    chk("R3", "clr_valid", int'(clr_valid), e_clr_v);
    if (e_clr_v != 0) begin
      chk("R3", "clr_id", int'(clr_id), e_clr_id);
      chk("R3", "clr_all", int'(clr_all), e_clr_all);
    end
    chk("R5", "set_valid", int'(set_valid), e_set_v);
    if (e_set_v != 0) chk("R5", "set_id", int'(set_id), e_set_id);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_ack(int id);
    hp_id = 10'(id); ack_req = 1; cyc(); ack_req = 0;
  endtask

  task automatic do_eoi(int id);
    eoi_id = 10'(id); eoi_req = 1; cyc(); eoi_req = 0;
  endtask

  task automatic setp(int id, int p);
    prio_flat[id*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    @(negedge clk);
    chk("R9", "reset run_id", int'(run_id), 1023);
    chk("R9", "reset run_prio", int'(run_prio), 256);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset pulses", int'(ack_valid | clr_valid | set_valid), 0);
    setp(5, 8'h80); setp(3, 8'h80); setp(9, 8'h40); setp(12, 8'h20); setp(20, 8'h60);
    model_1n[9] = 1;
    cyc();
    // R1: nothing pending, out-of-range ID
    do_ack(1023); do_ack(70);
    do_ack(5);                       // R2
    do_ack(3);                       // R1: tie refused
    chk("R1", "tie refused", int'(ack_id), 1023);
    do_ack(9);                       // R3: clr_all from model bit
    do_ack(12);
    // R4: ignored completions
    do_eoi(100);
    chk("R4", "bad id no set", int'(set_valid), 0);
    do_eoi(1023);
    chk("R4", "spurious keeps run", int'(run_id), 12);
    // R7: splice middle of chain 12->9->5
    do_eoi(9);
    // R8: requests while busy ignored
    hp_id = 10'd0; ack_req = 1; eoi_id = 10'd12; eoi_req = 1; cyc();
    chk("R8", "no ack while busy", int'(ack_valid), 0);
    ack_req = 0; eoi_req = 0;
    repeat (2) cyc();
    do_eoi(12);                      // R6: back to 5
    chk("R6", "popped to 5", int'(run_id), 5);
    do_eoi(5);                       // R6: idle prio
    chk("R6", "idle prio", int'(run_prio), 256);
    do_eoi(5);                       // R4: idle ignored
    // deeper chain 12->9->20->5
    do_ack(5); do_ack(20); do_ack(9); do_ack(12);
    do_eoi(5);                       // R7: tail, three visits
    repeat (4) cyc();
    do_eoi(33);                      // R7: absent ID, walk to end
    repeat (4) cyc();
    do_eoi(12); do_eoi(9);
    chk("R7", "after splice", int'(run_id), 20);
    do_eoi(20);
    chk("R7", "chain emptied", int'(run_id), 1023);
    // R5: re-pend conditions
    setp(7, 8'h10);
    level_in[7] = 1; enabled[7] = 1; targets_me[7] = 1; trig_edge[7] = 0;
    do_ack(7); do_eoi(7);
    chk("R5", "level repend", int'(set_valid), 1);
    trig_edge[7] = 1; do_ack(7); do_eoi(7);
    chk("R5", "edge no repend", int'(set_valid), 0);
    trig_edge[7] = 0; enabled[7] = 0; do_ack(7); do_eoi(7);
    targets_me[7] = 0; enabled[7] = 1; do_ack(7); do_eoi(7);
    targets_me[7] = 1; level_in[7] = 0; do_ack(7); do_eoi(7);
    // R8: ack and eoi together, ack served
    do_ack(5);
    hp_id = 10'd9; ack_req = 1; eoi_id = 10'd5; eoi_req = 1; cyc();
    ack_req = 0; eoi_req = 0;
    chk("R8", "ack wins", int'(run_id), 9);
    do_eoi(9); do_eoi(5);
    // random phase
    for (int i = 0; i < N; i++) setp(i, int'($urandom_range(0, 255)));
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ack_req = (r < 40);
      eoi_req = (r >= 30 && r < 75);
      hp_id = ($urandom_range(0, 9) == 0) ? 10'd1023 : 10'($urandom_range(0, 15));
      eoi_id = ($urandom_range(0, 15) == 0) ? 10'($urandom_range(64, 1023))
                                           : 10'($urandom_range(0, 15));
      level_in = N'({$urandom, $urandom});
      trig_edge = N'({$urandom, $urandom});
      model_1n = N'({$urandom, $urandom});
      enabled = N'({$urandom, $urandom}) | N'({$urandom, $urandom});
      targets_me = ~N'(0);
      cyc();
    end
    ack_req = 0; eoi_req = 0;
    cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule